// File: doc/BRIEF.md
# Partial-Word Store Lane Unit

This unit converts a "store bytes" request into one word-aligned memory transaction. A request carries a byte address, a 32-bit register value and a mode bit. In begin mode, the low-order bytes of the register are written from the addressed byte to the end of its word. In end mode, the high-order bytes are written from the start of the word up to, but not including, the addressed byte. Memory is big-endian, so lane 0 of a word is data bits 31:24.

Each request is issued as a single aligned write with a byte-enable mask. A three-byte store is therefore indivisible at the memory port. An end-mode request at a word-aligned address writes no byte. It produces a probe strobe instead, so that the memory side can still check write permission and mark the line dirty. The request side and the memory side each use a valid/ready handshake, and one output register sits between them.

Top module: `stby_lane_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, neither `mem_wr` nor `mem_probe` is high and `req_ready` is high.
- R2: In begin mode (`req_end`=0) with address offset o = addr[1:0], the byte enables cover lanes o through 3. Bit i of `mem_be` enables data bits [8i+7:8i], so lane 0 is `mem_be[3]`. The mask is therefore 4'hF >> o: offset 0 gives 1111, offset 1 gives 0111, offset 2 gives 0011 and offset 3 gives 0001.
- R3: In end mode (`req_end`=1) with offset o > 0, the byte enables cover lanes 0 through o-1. Offset 1 gives 1000, offset 2 gives 1100 and offset 3 gives 1110.
- R4: In end mode with offset 0, the transaction raises `mem_probe` instead of `mem_wr`, with `mem_be` equal to 0000.
- R5: `mem_wdata` equals the register value, unshifted. Each enabled lane therefore carries the intended register byte: the low bytes in begin mode and the high bytes in end mode.
- R6: `mem_addr` equals the request address with its two low bits cleared.
- R7: Each accepted request yields exactly one transaction, either a write or a probe and never both, one cycle after acceptance when the output stage is free.
- R8: While `mem_wr` or `mem_probe` is high and `mem_ready` is low, the strobe, address, data and enables stay unchanged on the next cycle.
- R9: `req_ready` is high exactly when the output stage is empty or `mem_ready` is high, so back-to-back requests are accepted one per cycle while memory accepts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W (32) | Byte address of the request |
| req_data | input | 8*LANES (32) | Register value to store |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| mem_wr | output | 1 | Write transaction valid |
| mem_probe | output | 1 | Probe-for-write transaction valid (no bytes written) |
| mem_ready | input | 1 | Memory accepts the current transaction |
| mem_addr | output | ADDR_W (32) | Word-aligned address |
| mem_wdata | output | 8*LANES (32) | Write data, one byte per lane |
| mem_be | output | LANES (4) | Active-high byte enables, bit LANES-1 is lane 0 |

## Verification
The assertions check four things on every cycle:
- A write and a probe are never raised together.
- A stalled transaction holds still.
- Addresses leave the unit aligned.
- A probe carries no enables, and every write mask is non-empty and touches one end of the word.

Only the bench's scenarios can show the properties that depend on the request that was accepted. These are the exact mask chosen for each mode and offset pairing, the data that reaches the lanes, and the one-for-one mapping between accepted requests and transactions under random backpressure. The bench model predicts these independently of the design.

// File: rtl/stby_pkg.sv
`timescale 1ns/1ps
package stby_pkg;
   typedef enum logic {
      STBY_BEGIN = 1'b0,
      STBY_END   = 1'b1
   } stby_mode_e;
endpackage

// File: rtl/stby_lane_mask.sv
`timescale 1ns/1ps
module stby_lane_mask
   import stby_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int LANE_BITS = $clog2(LANES)
) (
   input  logic [LANE_BITS-1:0] offset,
   input  stby_mode_e           mode,
   output logic [LANES-1:0]     be,
   output logic                 probe_only
);
   // lane k (big-endian index) maps to enable bit LANES-1-k
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [LANE_BITS-1:0] K = LANE_BITS'(k);
      always_comb begin
         if (mode == STBY_END) be[LANES-1-k] = (K < offset);
         else                  be[LANES-1-k] = (K >= offset);
      end
   end

   assign probe_only = (mode == STBY_END) && (offset == '0);
endmodule

// File: rtl/stby_hold_reg.sv
`timescale 1ns/1ps
module stby_hold_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end
endmodule

// File: rtl/stby_lane_unit.sv
`timescale 1ns/1ps
module stby_lane_unit
   import stby_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [8*LANES-1:0]   req_data,
   input  logic                 req_end,
   output logic                 mem_wr,
   output logic                 mem_probe,
   input  logic                 mem_ready,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [8*LANES-1:0]   mem_wdata,
   output logic [LANES-1:0]     mem_be
);
   localparam int DATA_W    = 8 * LANES;
   localparam int LANE_BITS = $clog2(LANES);
   localparam int PAY_W     = ADDR_W + DATA_W + LANES + 1;

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (ADDR_W <= LANE_BITS) begin : g_bad_addr
      $error("ADDR_W must exceed the lane offset width");
   end

   logic [LANES-1:0]   be_n;
   logic               probe_n;
   logic [ADDR_W-1:0]  addr_al;
   logic [PAY_W-1:0]   pay_in, pay_out;
   logic               out_vld;
   logic               probe_q;
   stby_mode_e         mode;

   assign mode    = stby_mode_e'(req_end);
   assign addr_al = {req_addr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};

   stby_lane_mask #(.LANES(LANES)) i_mask (
      .offset     (req_addr[LANE_BITS-1:0]),
      .mode       (mode),
      .be         (be_n),
      .probe_only (probe_n)
   );

   assign pay_in = {addr_al, req_data, be_n, probe_n};

   stby_hold_reg #(.W(PAY_W)) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_ready  (req_ready),
      .in_data   (pay_in),
      .out_valid (out_vld),
      .out_ready (mem_ready),
      .out_data  (pay_out)
   );

   assign {mem_addr, mem_wdata, mem_be, probe_q} = pay_out;
   assign mem_wr    = out_vld && !probe_q;
   assign mem_probe = out_vld &&  probe_q;
endmodule

// File: rtl/stby_lane_unit_chk.sv
`timescale 1ns/1ps
module stby_lane_unit_chk #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mem_wr,
   input logic                 mem_probe,
   input logic                 mem_ready,
   input logic [ADDR_W-1:0]    mem_addr,
   input logic [8*LANES-1:0]   mem_wdata,
   input logic [LANES-1:0]     mem_be
);
   localparam int LANE_BITS = $clog2(LANES);

   AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && mem_probe)); // R7

   AST_PROBE_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_probe |-> (mem_be == '0)); // R4

   AST_WR_EDGE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_be[0] || mem_be[LANES-1])); // R2 R3

   AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr || mem_probe) |-> (mem_addr[LANE_BITS-1:0] == '0)); // R6

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_wr || mem_probe) && !mem_ready) |=>
         ($stable(mem_wr) && $stable(mem_probe) && $stable(mem_addr)
          && $stable(mem_wdata) && $stable(mem_be))); // R8
endmodule

bind stby_lane_unit stby_lane_unit_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_wr    (mem_wr),
   .mem_probe (mem_probe),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_be    (mem_be)
);

// File: tb/test_stby_lane_unit.sv
`timescale 1ns/1ps
module test_stby_lane_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [31:0] req_data = '0;
   logic        req_end = 1'b0;
   logic        mem_wr, mem_probe;
   logic        mem_ready = 1'b1;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;

   int checks = 0;
   int errors = 0;
   int bp_mode = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   stby_lane_unit i_stby_lane_unit (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_end(req_end),
      .mem_wr(mem_wr), .mem_probe(mem_probe), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: one transaction slot
   logic        m_vld;
   logic        m_probe;
   logic [31:0] m_addr, m_data;
   logic [3:0]  m_be;
   logic        m_end;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_vld <= 1'b0;
      end else if (!m_vld || mem_ready) begin
         m_vld <= req_valid;
         if (req_valid) begin
            m_addr  <= req_addr & 32'hFFFF_FFFC;
            m_data  <= req_data;
            m_end   <= req_end;
            m_be    <= req_end ? (~(4'hF >> req_addr[1:0]) & 4'hF) : (4'hF >> req_addr[1:0]);
            m_probe <= req_end && (req_addr[1:0] == 2'd0);
         end
      end
   end

   // Cycle-by-cycle comparison and stall stability
   logic        p_vld = 1'b0;
   logic [31:0] p_addr, p_data;
   logic [3:0]  p_be;
   logic        p_wr, p_pr;

   always @(posedge clk) begin
      #1;
      cycles++;
      if (rst_n) begin
         check(mem_wr == (m_vld && !m_probe), "R7 write strobe", 32'(mem_wr), 32'(m_vld && !m_probe));
         check(mem_probe == (m_vld && m_probe), "R4 probe strobe", 32'(mem_probe), 32'(m_vld && m_probe));
         check(req_ready == (!m_vld || mem_ready), "R9 req_ready", 32'(req_ready), 32'(!m_vld || mem_ready));
         if (m_vld) begin
            check(mem_addr == m_addr, "R6 aligned address", mem_addr, m_addr);
            check(mem_be == m_be, m_probe ? "R4 probe mask" : (m_end ? "R3 end mask" : "R2 begin mask"),
                  32'(mem_be), 32'(m_be));
            if (!m_probe) check(mem_wdata == m_data, "R5 write data", mem_wdata, m_data);
         end
         if (p_vld && !mem_ready) begin
            check({p_wr, p_pr, p_addr, p_data, p_be} == {mem_wr, mem_probe, mem_addr, mem_wdata, mem_be},
                  "R8 stalled outputs held", mem_addr, p_addr);
         end
      end
      p_vld  = mem_wr || mem_probe;
      p_wr   = mem_wr;
      p_pr   = mem_probe;
      p_addr = mem_addr;
      p_data = mem_wdata;
      p_be   = mem_be;
   end

   always @(negedge clk) begin
      if (bp_mode == 0) mem_ready = 1'b1;
      else              mem_ready = ($urandom % 3) != 0;
   end

   task automatic send(input logic [31:0] a, input logic [31:0] d, input logic e);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_data  = d;
      req_end   = e;
      forever begin
         @(posedge clk);
         if (req_ready) break;
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic stimulus();
      repeat (3) @(negedge clk);
      check(!mem_wr && !mem_probe, "R1 strobes low in reset", 32'({mem_wr, mem_probe}), 32'h0);
      check(req_ready, "R1 ready in reset", 32'(req_ready), 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      check(!mem_wr && !mem_probe, "R1 strobes low after reset", 32'({mem_wr, mem_probe}), 32'h0);
      // every mode and offset pairing, memory always ready
      for (int e = 0; e < 2; e++)
         for (int o = 0; o < 4; o++)
            send(32'h1234_5670 + 32'(o) + 32'(e * 16), 32'hA1B2_C3D4 ^ 32'(o * 8 + e), e[0]);
      // back-to-back stream with held valid
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         req_valid = 1'b1;
         req_addr  = $urandom;
         req_data  = $urandom;
         req_end   = i[0];
         forever begin
            @(posedge clk);
            if (req_ready) break;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      // random backpressure and gaps
      bp_mode = 1;
      for (int i = 0; i < 300; i++) begin
         send($urandom, $urandom, 1'($urandom));
         if ($urandom % 4 == 0) @(negedge clk);
      end
      bp_mode = 0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      fork
         stimulus();
         begin
            wait (cycles > 100000);
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule